// File: doc/BRIEF.md
# External interrupt edge and source selector

This block turns six external interrupt pins into latched interrupt request flags. Each pin passes through a synchroniser and an edge detector. The detector fires on one chosen edge, falling or rising, or on both edges. Four of the eight request slots are shared. Slots 4 and 5 can be owned by a pin or by a serial-channel event. Two further slots can be owned by a timer event or by a bus-collision event.

Software configures the block through a small register port with four 8-bit locations, read back combinationally. It reads the request flags and clears them by writing 0. A flag that is being set in the same cycle as a clear stays set, so no event is lost.

Top module: `ext_irq_select`

## Requirements
- R1: After reset, all four locations read 0x00 and `irq_flag` is 0x00. Location 0 is the mode/select register, location 1 is the group-select register, location 2 is the polarity register and location 3 is the flag register.
- R2: When mode bit i (location 0, bit i, i = 0..5) is 0 and polarity bit i (location 2, bit i) is 0, a falling edge on `pin_in[i]` sets flag i and a rising edge does not. The flag appears on the third rising clock edge after the pin changes.
- R3: When mode bit i is 0 and polarity bit i is 1, a rising edge sets flag i and a falling edge does not.
- R4: When mode bit i is 1, both rising and falling edges set flag i.
- R5: Location 0 bit 6 picks the owner of flag 4: 0 means `ser_evt[0]` and 1 means pin 4. Bit 7 picks the owner of flag 5: 0 means `ser_evt[1]` and 1 means pin 5. An event from the source that is not selected never sets the flag.
- R6: Location 1 bit 6 picks the owner of flag 6: 0 means `tmr_evt[0]` and 1 means `bcol_evt[0]`. Bit 7 picks the owner of flag 7 in the same way, from `tmr_evt[1]` or `bcol_evt[1]`. An event from the source that is not selected is discarded.
- R7: Bits 5:0 of location 1 ignore writes and read 0. Bits 7:6 of location 2 ignore writes and read 0.
- R8: A flag stays set until a write to location 3 carries 0 in that bit. A 1 in the write data leaves the bit unchanged.
- R9: When a set and a clear reach the same flag in one cycle, the flag ends set.
- R10: Writing location 0 or location 1, including a change of a select bit, leaves every pending flag unchanged.
- R11: One pin edge sets its flag only once. After software clears the flag, a pin held at its new level does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 6 | Asynchronous external interrupt pins |
| ser_evt | input | 2 | Serial-channel event pulses for slots 4 and 5 |
| tmr_evt | input | 2 | Timer event pulses for slots 6 and 7 |
| bcol_evt | input | 2 | Bus-collision event pulses for slots 6 and 7 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register location |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for location `addr` |
| irq_flag | output | 8 | Latched request flags, one per slot |

## Verification
The bench builds the block with its default of two synchroniser stages. With this setting the pin-to-flag latency is a fixed three clocks. A cycle-level expectation computed in the bench can therefore follow every flag through random pin toggles, random event pulses and random register writes. Directed cases cover polarity, both-edge mode, source ownership, write-0 clearing, set winning over clear, and a level held after an edge.

// File: rtl/ext_irq_select.sv
module ext_irq_select #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] pin_in,
  input  logic [1:0] ser_evt,
  input  logic [1:0] tmr_evt,
  input  logic [1:0] bcol_evt,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] irq_flag
);

  localparam logic [1:0] LOC_MODE = 2'd0;
  localparam logic [1:0] LOC_GRP  = 2'd1;
  localparam logic [1:0] LOC_POL  = 2'd2;
  localparam logic [1:0] LOC_FLAG = 2'd3;

  logic [5:0] sync_q [SYNC_STAGES];
  logic [5:0] prev_q;
  logic [5:0] mode_q, pol_q;
  logic [1:0] sel_q, grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  wire [5:0] cur  = sync_q[SYNC_STAGES-1];
  wire [5:0] rise = cur & ~prev_q;
  wire [5:0] fall = ~cur & prev_q;
  wire [5:0] pin_hit = (mode_q & (rise | fall)) |
                       (~mode_q & ((pol_q & rise) | (~pol_q & fall)));

  wire [7:0] set_vec = {
    grp_q[1] ? bcol_evt[1] : tmr_evt[1],
    grp_q[0] ? bcol_evt[0] : tmr_evt[0],
    sel_q[1] ? pin_hit[5]  : ser_evt[1],
    sel_q[0] ? pin_hit[4]  : ser_evt[0],
    pin_hit[3:0]
  };

  wire [7:0] clr_vec = (wr_en && addr == LOC_FLAG) ? ~wdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      sel_q    <= '0;
      grp_q    <= '0;
      pol_q    <= '0;
      irq_flag <= '0;
    end else begin
      if (wr_en && addr == LOC_MODE) {sel_q, mode_q} <= wdata;
      if (wr_en && addr == LOC_GRP)  grp_q <= wdata[7:6];
      if (wr_en && addr == LOC_POL)  pol_q <= wdata[5:0];
      irq_flag <= set_vec | (irq_flag & ~clr_vec);
    end
  end

  always_comb begin
    case (addr)
      LOC_MODE: rdata = {sel_q, mode_q};
      LOC_GRP:  rdata = {grp_q, 6'b0};
      LOC_POL:  rdata = {2'b0, pol_q};
      default:  rdata = irq_flag;
    endcase
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 8'h00) |=> ((irq_flag & $past(set_vec)) == $past(set_vec)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == LOC_FLAG) |=> ((~irq_flag & $past(irq_flag)) == 8'h00));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == LOC_FLAG && set_vec == 8'h00) |=> ((irq_flag & ~$past(wdata)) == 8'h00));

  // R5
  unselected_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q[0] && !ser_evt[0] && !irq_flag[4]) |=> !irq_flag[4]);

  // R6
  unselected_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_q[0] && !tmr_evt[0] && !irq_flag[6]) |=> !irq_flag[6]);

  // R7
  reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == LOC_GRP) |-> (rdata[5:0] == 6'b0));

endmodule

// File: tb/test_ext_irq_select.sv
`timescale 1ns/1ps
module test_ext_irq_select;
  logic clk = 0, rst_n = 0;
  logic [5:0] pin_in = 0;
  logic [1:0] ser_evt = 0, tmr_evt = 0, bcol_evt = 0;
  logic wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, irq_flag;

  ext_irq_select i_ext_irq_select (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [5:0] pins = 0;
  logic [1:0] ser = 0, tmr = 0, bcol = 0;
  logic [5:0] ph0 = 0, ph1 = 0, ph2 = 0;
  logic [5:0] m_mode = 0, m_pol = 0;
  logic [1:0] m_sel = 0, m_grp = 0;
  logic [7:0] exp_flag = 0;

  function automatic logic [5:0] edges(logic [5:0] o, logic [5:0] n,
                                       logic [5:0] md, logic [5:0] pl);
    logic [5:0] r = n & ~o, f = ~n & o;
    return (md & (r | f)) | (~md & ((pl & r) | (~pl & f)));
  endfunction

  function automatic logic [7:0] read_exp(logic [1:0] a);
    case (a)
      2'd0: return {m_sel, m_mode};
      2'd1: return {m_grp, 6'b0};
      2'd2: return {2'b0, m_pol};
      default: return exp_flag;
    endcase
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] expv, string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
    end
  endtask

  task automatic step(logic we, logic [1:0] a, logic [7:0] wd, string tag);
    logic [5:0] hit;
    logic [7:0] setv, clrv;
    @(negedge clk);
    pin_in = pins; ser_evt = ser; tmr_evt = tmr; bcol_evt = bcol;
    wr_en = we; addr = a; wdata = wd;
    hit = edges(ph2, ph1, m_mode, m_pol);
    setv = {m_grp[1] ? bcol[1] : tmr[1], m_grp[0] ? bcol[0] : tmr[0],
            m_sel[1] ? hit[5] : ser[1], m_sel[0] ? hit[4] : ser[0], hit[3:0]};
    clrv = (we && a == 2'd3) ? ~wd : 8'h00;
    exp_flag = setv | (exp_flag & ~clrv);
    if (we && a == 2'd0) {m_sel, m_mode} = wd;
    if (we && a == 2'd1) m_grp = wd[7:6];
    if (we && a == 2'd2) m_pol = wd[5:0];
    ph2 = ph1; ph1 = ph0; ph0 = pins;
    ser = 0; tmr = 0; bcol = 0;
    @(posedge clk);
    #1;
    chk(irq_flag, exp_flag, tag);
    chk(rdata, read_exp(a), tag);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(0, 2'd3, 8'h00, tag);
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] lit, string tag);
    step(0, a, 8'h00, tag);
    chk(rdata, lit, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0021));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(irq_flag, 8'h00, "R1");
    for (int a = 0; a < 4; a++) rd(a[1:0], 8'h00, "R1");

    // R2 falling edge only
    pins[0] = 1; idle(5, "R2");
    chk(irq_flag, 8'h00, "R2 rise ignored");
    pins[0] = 0; idle(2, "R2");
    chk({7'b0, irq_flag[0]}, 8'h00, "R2 latency");
    idle(1, "R2");
    chk({7'b0, irq_flag[0]}, 8'h01, "R2 falling");
    step(1, 2'd3, 8'h00, "R8");

    // R3 rising edge
    step(1, 2'd2, 8'h02, "R3");
    pins[1] = 1; idle(4, "R3");
    chk(irq_flag, 8'h02, "R3 rising");
    step(1, 2'd3, 8'h00, "R3");
    pins[1] = 0; idle(5, "R3");
    chk(irq_flag, 8'h00, "R3 fall ignored");

    // R4 both edges
    step(1, 2'd0, 8'h04, "R4");
    pins[2] = 1; idle(4, "R4");
    chk(irq_flag, 8'h04, "R4 rise");
    step(1, 2'd3, 8'h00, "R4");
    // R11 held level does not retrigger
    idle(6, "R11");
    chk(irq_flag, 8'h00, "R11");
    pins[2] = 0; idle(4, "R4");
    chk(irq_flag, 8'h04, "R4 fall");
    step(1, 2'd3, 8'h00, "R4");

    // R5 slot 4 ownership
    pins[4] = 1; idle(4, "R5"); pins[4] = 0; idle(4, "R5");
    chk(irq_flag, 8'h00, "R5 pin4 discarded");
    ser[0] = 1; step(0, 2'd3, 0, "R5");
    chk(irq_flag, 8'h10, "R5 serial owner");
    // R10 select change keeps flag
    step(1, 2'd0, 8'h44, "R10");
    chk(irq_flag, 8'h10, "R10");
    step(1, 2'd3, 8'h00, "R5");
    ser[0] = 1; step(0, 2'd3, 0, "R5");
    chk(irq_flag, 8'h00, "R5 serial discarded");
    pins[4] = 1; idle(4, "R5"); pins[4] = 0; idle(4, "R5");
    chk(irq_flag, 8'h10, "R5 pin4 owner");
    step(1, 2'd3, 8'h00, "R5");

    // R6 group slots
    bcol[0] = 1; step(0, 2'd3, 0, "R6");
    chk(irq_flag, 8'h00, "R6 bcol discarded");
    tmr[0] = 1; step(0, 2'd3, 0, "R6");
    chk(irq_flag, 8'h40, "R6 timer owner");
    step(1, 2'd1, 8'hC0, "R10");
    chk(irq_flag, 8'h40, "R10 group change");
    tmr[1] = 1; step(0, 2'd3, 0, "R6");
    chk(irq_flag, 8'h40, "R6 timer discarded");
    bcol[1] = 1; step(0, 2'd3, 0, "R6");
    chk(irq_flag, 8'hC0, "R6 bcol owner");

    // R7 reserved bits
    step(1, 2'd1, 8'hFF, "R7");
    rd(2'd1, 8'hC0, "R7");
    step(1, 2'd2, 8'hFF, "R7");
    rd(2'd2, 8'h3F, "R7");
    step(1, 2'd2, 8'h00, "R7");

    // R8 write-1 keeps, write-0 clears
    step(1, 2'd3, 8'hFF, "R8");
    chk(irq_flag, 8'hC0, "R8 keep");
    step(1, 2'd3, 8'h7F, "R8");
    chk(irq_flag, 8'h40, "R8 clear");

    // R9 set beats clear
    ser[1] = 1; step(1, 2'd3, 8'h00, "R9");
    chk(irq_flag, 8'h20, "R9");
    step(1, 2'd3, 8'h00, "R9");

    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [1:0] a;
      logic we;
      if ($urandom_range(0, 3) == 0) pins[$urandom_range(0, 5)] ^= 1'b1;
      ser = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b0;
      tmr = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b0;
      bcol = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b0;
      we = ($urandom_range(0, 5) == 0);
      a = 2'($urandom);
      step(we, a, 8'($urandom), "random R2-R9");
    end
    finish_run();
  end
endmodule